// File: doc/BRIEF.md
# Flash Program/Erase Pulse Timer

This block times the high-voltage phases of flash program and erase operations. A slow timing tick is derived from the bus clock by a divider. Software sets the divider value once after reset, choosing it so that the tick rate lands between 150 kHz and 200 kHz. Each operation then holds its voltage-enable strobe for a fixed number of tick periods. The tick count depends on the operation kind, so a slower tick stretches every operation in proportion.

The divider register takes one write after reset. Any later write is dropped. A write made while the external access-error flag is high is also dropped. Until the divider has been set, every start request is refused. A start request that arrives while an operation is running is refused as well. Each refusal shows as a one-cycle error pulse. A started operation raises `busy` and the matching enable strobe. When its last tick has been counted it drops them and pulses `done` for one bus clock.

Top module: `nvm_seq_top`

## Requirements
- R1: After reset, `busy`, `done`, `div_set`, `cmd_err`, `prog_en` and `erase_en` are all 0.
- R2: A write with `div_wr_en`=1 and `acc_err_in`=0 while `div_set`=0 stores `div_wr_data` and sets `div_set` from the next cycle. `div_set` then stays 1 until reset.
- R3: Once `div_set` is 1, further divider writes are ignored, so operation durations keep using the first stored value.
- R4: A divider write made while `acc_err_in`=1 is ignored. `div_set` stays 0 and start requests are still refused.
- R5: A `cmd_start` seen while `div_set`=0 is refused: `busy` stays 0 and `cmd_err` is 1 for exactly the next cycle.
- R6: The tick period is D+1 bus clocks, where D is the stored divider value. An accepted start makes `busy` 1 from the next cycle, for exactly N*(D+1) cycles.
- R7: N depends on the 2-bit `cmd_code`: 0 = single byte program, 9 ticks; 1 = burst byte program, 4 ticks; 2 = page erase, 4000 ticks; 3 = mass erase, 20000 ticks.
- R8: `done` is 1 for exactly one cycle, which is the first cycle in which `busy` is 0 again.
- R9: A `cmd_start` seen while `busy`=1 gives `cmd_err`=1 in the next cycle. The running operation keeps its original kind and its original length.
- R10: `prog_en` is 1 exactly while `busy` is 1 with code 0 or 1. `erase_en` is 1 exactly while `busy` is 1 with code 2 or 3. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| div_wr_en | input | 1 | Divider register write strobe |
| div_wr_data | input | DIV_W | Divider value D; tick period is D+1 bus clocks |
| acc_err_in | input | 1 | External access-error flag; blocks divider writes |
| cmd_start | input | 1 | Operation start request |
| cmd_code | input | 2 | Operation kind: 0 byte program, 1 burst program, 2 page erase, 3 mass erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_set | output | 1 | Divider register has been written |
| cmd_err | output | 1 | One-cycle pulse for a refused start |
| prog_en | output | 1 | Program voltage enable |
| erase_en | output | 1 | Erase voltage enable |

## Verification
A wrong prescaler phase or tick-counter value shows at the ports as a `busy` window of the wrong length. The window is off by a multiple of D+1 cycles when the counter is wrong, and off by a fraction of a tick period when the prescaler is wrong. The mismatch appears at the single cycle where `done` should pulse. A lost or wrongly set divider-written flag shows on the very next start request, through an unexpected `cmd_err` pulse or an unexpected `busy`. A latched operation kind that is corrupted shows in the same cycle as a swapped enable strobe, or as a duration that belongs to a different kind.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    typedef enum logic [1:0] {
        OP_BYTE_PROG  = 2'd0,
        OP_BURST_PROG = 2'd1,
        OP_PAGE_ERASE = 2'd2,
        OP_MASS_ERASE = 2'd3
    } op_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        op_kind_e   kind;
    } seq_ctx_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic logic is_erase(input op_kind_e k);
        return (k == OP_PAGE_ERASE) || (k == OP_MASS_ERASE);
    endfunction

endpackage

// File: rtl/nvm_div_reg.sv
module nvm_div_reg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             acc_err,
    output logic [DIV_W-1:0] div_val,
    output logic             locked
);
    logic take;

    assign take = wr_en && !locked && !acc_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_val <= '0;
            locked  <= 1'b0;
        end else if (take) begin
            div_val <= wr_data;
            locked  <= 1'b1;
        end
    end
endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] phase;

    assign tick = run && (phase == div_val);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= (phase == div_val) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/nvm_op_ctrl.sv
module nvm_op_ctrl
    import nvm_seq_pkg::*;
#(
    parameter int BYTE_TICKS  = 9,
    parameter int BURST_TICKS = 4,
    parameter int PAGE_TICKS  = 4000,
    parameter int MASS_TICKS  = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] code,
    input  logic       armed,
    input  logic       tick,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       refuse,
    output logic       prog_en,
    output logic       erase_en
);
    localparam int MAXT  = max4(BYTE_TICKS, BURST_TICKS, PAGE_TICKS, MASS_TICKS);
    localparam int CNT_W = $clog2(MAXT + 1);

    seq_ctx_t         ctx;
    logic [CNT_W-1:0] left;
    logic [CNT_W-1:0] load_val;
    logic             last;

    always_comb begin
        case (op_kind_e'(code))
            OP_BYTE_PROG:  load_val = CNT_W'(BYTE_TICKS);
            OP_BURST_PROG: load_val = CNT_W'(BURST_TICKS);
            OP_PAGE_ERASE: load_val = CNT_W'(PAGE_TICKS);
            default:       load_val = CNT_W'(MASS_TICKS);
        endcase
    end

    assign busy     = (ctx.state == ST_RUN);
    assign accept   = start && armed && !busy;
    assign last     = tick && (left == CNT_W'(1));
    assign prog_en  = busy && !is_erase(ctx.kind);
    assign erase_en = busy && is_erase(ctx.kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.state <= ST_IDLE;
            ctx.kind  <= OP_BYTE_PROG;
            left      <= '0;
            done      <= 1'b0;
            refuse    <= 1'b0;
        end else begin
            done   <= 1'b0;
            refuse <= start && (!armed || busy);
            if (accept) begin
                ctx.state <= ST_RUN;
                ctx.kind  <= op_kind_e'(code);
                left      <= load_val;
            end else if (busy && tick) begin
                left <= left - 1'b1;
                if (last) begin
                    ctx.state <= ST_IDLE;
                    done      <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/nvm_seq_top.sv
module nvm_seq_top #(
    parameter int DIV_W       = 8,
    parameter int BYTE_TICKS  = 9,
    parameter int BURST_TICKS = 4,
    parameter int PAGE_TICKS  = 4000,
    parameter int MASS_TICKS  = 20000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr_en,
    input  logic [DIV_W-1:0] div_wr_data,
    input  logic             acc_err_in,
    input  logic             cmd_start,
    input  logic [1:0]       cmd_code,
    output logic             busy,
    output logic             done,
    output logic             div_set,
    output logic             cmd_err,
    output logic             prog_en,
    output logic             erase_en
);
    logic [DIV_W-1:0] div_val;
    logic             tick;
    logic             accept;

    nvm_div_reg #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (div_wr_en),
        .wr_data (div_wr_data),
        .acc_err (acc_err_in),
        .div_val (div_val),
        .locked  (div_set)
    );

    nvm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (accept),
        .run     (busy),
        .div_val (div_val),
        .tick    (tick)
    );

    nvm_op_ctrl #(
        .BYTE_TICKS  (BYTE_TICKS),
        .BURST_TICKS (BURST_TICKS),
        .PAGE_TICKS  (PAGE_TICKS),
        .MASS_TICKS  (MASS_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (cmd_start),
        .code     (cmd_code),
        .armed    (div_set),
        .tick     (tick),
        .accept   (accept),
        .busy     (busy),
        .done     (done),
        .refuse   (cmd_err),
        .prog_en  (prog_en),
        .erase_en (erase_en)
    );
endmodule

// File: rtl/nvm_seq_chk.sv
module nvm_seq_chk (
    input logic clk,
    input logic rst,
    input logic div_wr_en,
    input logic acc_err_in,
    input logic cmd_start,
    input logic busy,
    input logic done,
    input logic div_set,
    input logic cmd_err,
    input logic prog_en,
    input logic erase_en
);
    p_divset_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        div_set |=> div_set);

    p_errwrite_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        (!div_set && acc_err_in) |=> !div_set);

    p_unset_refused_r5: assert property (@(posedge clk) disable iff (rst)
        (!div_set && cmd_start) |=> (!busy && cmd_err));

    p_rise_needs_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(cmd_start) && $past(div_set)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_busy_start_err_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_start) |=> cmd_err);

    p_enables_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(prog_en && erase_en));

    p_enables_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (prog_en || erase_en) == busy);

    p_kind_held_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(prog_en) && $stable(erase_en)));
endmodule

bind nvm_seq_top nvm_seq_chk u_chk (.*);

// File: tb/nvm_seq_top_tb.sv
module nvm_seq_top_tb;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             div_wr_en;
    logic [DIV_W-1:0] div_wr_data;
    logic             acc_err_in;
    logic             cmd_start;
    logic [1:0]       cmd_code;
    logic             busy, done, div_set, cmd_err, prog_en, erase_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    nvm_seq_top u_dut (
        .clk(clk), .rst(rst), .div_wr_en(div_wr_en), .div_wr_data(div_wr_data),
        .acc_err_in(acc_err_in), .cmd_start(cmd_start), .cmd_code(cmd_code),
        .busy(busy), .done(done), .div_set(div_set), .cmd_err(cmd_err),
        .prog_en(prog_en), .erase_en(erase_en)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ticks_of(input int code);
        case (code)
            0: return 9;
            1: return 4;
            2: return 4000;
            default: return 20000;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1; div_wr_en = 1'b0; div_wr_data = '0; acc_err_in = 1'b0;
        cmd_start = 1'b0; cmd_code = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_div(input int v, input logic err);
        div_wr_en = 1'b1; div_wr_data = DIV_W'(v); acc_err_in = err;
        @(negedge clk);
        div_wr_en = 1'b0; acc_err_in = 1'b0;
    endtask

    // Starts an operation, optionally pokes a second start mid-run,
    // and checks length, done pulse and enables.
    task automatic run_op(input int code, input int d, input bit poke);
        int len = 0;
        int en_bad = 0;
        int exp_len = ticks_of(code) * (d + 1);
        bit exp_erase = (code >= 2);
        cmd_code = 2'(code); cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (busy && len < 200000) begin
            len++;
            if (prog_en != !exp_erase || erase_en != exp_erase) en_bad++;
            if (poke && len == 3) begin
                cmd_code = 2'(3 - code); cmd_start = 1'b1;
            end else if (poke && len == 4) begin
                cmd_start = 1'b0;
                chk("R9 err on busy start", cmd_err, 1);
            end else begin
                cmd_start = 1'b0;
            end
            @(negedge clk);
        end
        chk($sformatf("R6/R7 busy length code %0d div %0d", code, d), len, exp_len);
        chk("R10 enable strobes", en_bad, 0);
        chk("R8 done on first idle cycle", done, 1);
        chk("R10 enables off when idle", prog_en | erase_en, 0);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cyc++;
            if (cyc > 195000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected 0", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 div_set reset", div_set, 0);
        chk("R1 cmd_err reset", cmd_err, 0);
        chk("R1 enables reset", prog_en | erase_en, 0);

        // R5: start before divider set
        cmd_code = 2'd0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R5 refused busy", busy, 0);
        chk("R5 refused err", cmd_err, 1);
        @(negedge clk);
        chk("R5 err one cycle", cmd_err, 0);

        // R4: write under access error ignored
        write_div(2, 1'b1);
        chk("R4 div_set stays 0", div_set, 0);
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R4 start still refused", busy, 0);
        chk("R4 refusal err", cmd_err, 1);

        // R2/R3 and sweep of small codes over several divider values
        for (int di = 0; di < 4; di++) begin
            int d = (di == 3) ? 5 : di;
            do_reset();
            write_div(d, 1'b0);
            chk("R2 div_set after write", div_set, 1);
            write_div(d + 7, 1'b0);
            chk("R2 div_set sticky", div_set, 1);
            for (int c = 0; c < 2; c++) run_op(c, d, 1'b0);
            run_op(0, d, 1'b1);
        end

        // page erase sweep (R3: second write of 0 ignored)
        for (int di = 0; di < 3; di++) begin
            int d = (di == 2) ? 3 : di;
            do_reset();
            write_div(d, 1'b0);
            write_div(0, 1'b0);
            run_op(2, d, di == 1);
        end

        // mass erase
        for (int d = 0; d < 2; d++) begin
            do_reset();
            write_div(d, 1'b0);
            write_div(9, 1'b0);
            run_op(3, d, d == 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule